// File: doc/BRIEF.md
# Stack-Based Arithmetic Evaluation Unit

This block is a zero-address arithmetic engine. Operands live in a small last-in first-out store built from registers. A count register names the top of that store. Each command is presented for one clock with a valid strobe. A command can push a 16-bit operand, pop the top value, add the two top values, or multiply them. Add and multiply consume both operands and leave the result on top. An expression such as (A+B)*(C+D) is therefore evaluated as a plain sequence of commands, with no general registers involved.

Every accepted command produces a single done pulse on the next cycle. The pulse carries a status bit and a result word. A failed command is one that would overflow or underflow the store, and it leaves the store exactly as it was. The store holds five entries by default. The empty and full conditions come from comparing the count against two fixed bounds.

Top module: `stack_calc`

## Requirements
- R1: While reset is asserted and after its release, done_o, status_o and rd_data_o are 0 and the store is empty.
- R2: Each clock edge that samples cmd_valid_i high is followed one cycle later by exactly one done_o pulse. done_o is low in every other cycle.
- R3: A push (cmd_op_i = 2'b00) onto a store holding DEPTH entries is an overflow. It returns status_o = 1 and rd_data_o = 0, and it leaves the count and the contents unchanged.
- R4: A pop (2'b01), add (2'b10) or multiply (2'b11) on an empty store is an underflow. It returns status_o = 1 and rd_data_o = 0, and it changes nothing.
- R5: An add or multiply with exactly one entry stored is an underflow. It returns status_o = 1, and the single entry stays in place.
- R6: Pop returns the most recently pushed value that has not yet been removed, on rd_data_o, and lowers the count by one.
- R7: Add removes the two top entries and pushes their sum, truncated to 16 bits. The sum is also returned on rd_data_o.
- R8: Multiply removes the two top entries and pushes the low 16 bits of their product. That value is also returned on rd_data_o.
- R9: A successful command returns status_o = 0. A successful push returns the pushed word on rd_data_o and raises the count by one.
- R10: The sequence push 25, push 17, add, push 3, push 2, add, multiply, pop returns 210 on the final pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle high |
| cmd_op_i | input | 2 | 00 push, 01 pop, 10 add, 11 multiply |
| cmd_data_i | input | 16 | Operand for push |
| rd_data_o | output | 16 | Result word of the last command, held between commands |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 1 | 0 success, 1 overflow or underflow, valid with done_o |

## Verification
The assertions check the following on every cycle:
- the one-cycle link between the strobe and done_o;
- that the count stays within the store's depth;
- that a push on a full store, and an operation on an empty or single-entry store, are flagged and leave the count stable;
- that a successful push raises the count by one.

Only the bench's scenarios can show that data comes back in last-in first-out order, that sums and products are truncated correctly, that a failed command leaves the stored values untouched, and that the full expression yields 210. The bench does this by comparing every result against a queue model.

// File: rtl/stack_calc_pkg.sv
package stack_calc_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_MUL  = 2'b11
  } op_e;
endpackage

// File: rtl/stack_calc_ptr.sv
module stack_calc_ptr
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  op_e           op_i,
  output logic [PW-1:0] sp_o,
  output logic          err_o,
  output logic          commit_o
);
  localparam logic [PW-1:0] SpEmpty = '0;
  localparam logic [PW-1:0] SpFull  = PW'(DEPTH);

  logic [PW-1:0] sp_q, sp_d;

  always_comb begin
    err_o = 1'b0;
    sp_d  = sp_q;
    unique case (op_i)
      OP_PUSH: begin err_o = (sp_q == SpFull);   sp_d = sp_q + PW'(1); end
      OP_POP:  begin err_o = (sp_q == SpEmpty);  sp_d = sp_q - PW'(1); end
      default: begin err_o = (sp_q < PW'(2));    sp_d = sp_q - PW'(1); end
    endcase
  end

  assign commit_o = valid_i && !err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sp_q <= SpEmpty;
    else if (commit_o) sp_q <= sp_d;
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/stack_calc_regs.sv
module stack_calc_regs #(
  parameter int DEPTH = 5,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_a_i,
  input  logic [PW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           mem_q[i] <= '0;
      else if (we_i && waddr_i == PW'(i))    mem_q[i] <= wdata_i;
    end
  end

  // out-of-range addresses read as zero
  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (raddr_a_i == PW'(i)) rdata_a_o = mem_q[i];
      if (raddr_b_i == PW'(i)) rdata_b_o = mem_q[i];
    end
  end
endmodule

// File: rtl/stack_calc_alu.sv
module stack_calc_alu
  import stack_calc_pkg::*;
#(
  parameter int DW = 16
) (
  input  op_e           op_i,
  input  logic [DW-1:0] lhs_i,
  input  logic [DW-1:0] rhs_i,
  output logic [DW-1:0] res_o
);
  // results keep the low DW bits
  always_comb begin
    if (op_i == OP_MUL) res_o = lhs_i * rhs_i;
    else                res_o = lhs_i + rhs_i;
  end
endmodule

// File: rtl/stack_calc.sv
module stack_calc
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int DW    = 16,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [1:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          status_o
);
  op_e           op;
  logic [PW-1:0] sp_q;
  logic          err, commit;
  logic [PW-1:0] top_idx, nxt_idx, waddr;
  logic [DW-1:0] top_val, nxt_val, alu_res, wdata, result;
  logic          we;
  logic          done_q, status_q;
  logic [DW-1:0] rd_q;

  assign op = op_e'(cmd_op_i);

  stack_calc_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i, .rst_ni, .valid_i(cmd_valid_i), .op_i(op),
    .sp_o(sp_q), .err_o(err), .commit_o(commit)
  );

  assign top_idx = sp_q - PW'(1);
  assign nxt_idx = sp_q - PW'(2);

  stack_calc_regs #(.DEPTH(DEPTH), .DW(DW)) i_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(top_idx), .raddr_b_i(nxt_idx),
    .rdata_a_o(top_val), .rdata_b_o(nxt_val)
  );

  stack_calc_alu #(.DW(DW)) i_alu (
    .op_i(op), .lhs_i(nxt_val), .rhs_i(top_val), .res_o(alu_res)
  );

  // push writes above the top; arithmetic overwrites the lower operand
  assign we    = commit && (op != OP_POP);
  assign waddr = (op == OP_PUSH) ? sp_q : nxt_idx;
  assign wdata = (op == OP_PUSH) ? cmd_data_i : alu_res;

  always_comb begin
    unique case (op)
      OP_PUSH: result = cmd_data_i;
      OP_POP:  result = top_val;
      default: result = alu_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      status_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      done_q   <= cmd_valid_i;
      status_q <= cmd_valid_i && err;
      if (cmd_valid_i) rd_q <= err ? '0 : result;
    end
  end

  assign done_o    = done_q;
  assign status_o  = status_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/stack_calc_chk.sv
module stack_calc_chk
  import stack_calc_pkg::*;
#(
  parameter int DEPTH = 5,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_valid_i,
  input logic [1:0]    cmd_op_i,
  input logic          done_o,
  input logic          status_o,
  input logic [PW-1:0] sp_q
);
  assert_done_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);

  assert_no_spurious_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);

  assert_depth_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= PW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_PUSH && sp_q == PW'(DEPTH))
      |=> (status_o && $stable(sp_q)));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i != OP_PUSH && sp_q == '0)
      |=> (status_o && $stable(sp_q)));

  assert_single_operand_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i[1] && sp_q == PW'(1))
      |=> (status_o && $stable(sp_q)));

  assert_push_ok_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_PUSH && sp_q < PW'(DEPTH))
      |=> (!status_o && sp_q == $past(sp_q) + PW'(1)));
endmodule

bind stack_calc stack_calc_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .cmd_op_i(cmd_op_i), .done_o(done_o), .status_o(status_o), .sp_q(sp_q)
);

// File: tb/test_stack_calc.sv
module test_stack_calc;
  localparam int DEPTH = 5;
  localparam int CYCLE = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = 2'b00;
  logic [15:0] cmd_data_i = '0;
  logic [15:0] rd_data_o;
  logic        done_o, status_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model_q[$];

  always #(CYCLE/2) clk_i = ~clk_i;

  stack_calc i_stack_calc (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one command, predict with the queue model, check one cycle later
  task automatic run(input logic [1:0] op, input logic [15:0] d, input string tag);
    logic        e_err;
    logic [15:0] e_res, t, n;
    e_err = 1'b0;
    e_res = '0;
    case (op)
      2'b00: if (model_q.size() == DEPTH) e_err = 1'b1;
             else begin model_q.push_back(d); e_res = d; end
      2'b01: if (model_q.size() == 0) e_err = 1'b1;
             else e_res = model_q.pop_back();
      default:
             if (model_q.size() < 2) e_err = 1'b1;
             else begin
               t = model_q.pop_back();
               n = model_q.pop_back();
               e_res = (op == 2'b10) ? n + t : n * t;
               model_q.push_back(e_res);
             end
    endcase
    cmd_valid_i = 1'b1;
    cmd_op_i    = op;
    cmd_data_i  = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(done_o == 1'b1, {tag, " done R2"}, int'(done_o), 1);
    chk(status_o == e_err, {tag, " status"}, int'(status_o), int'(e_err));
    chk(rd_data_o == e_res, {tag, " data"}, int'(rd_data_o), int'(e_res));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      chk(done_o == 1'b0, "idle no done R2", int'(done_o), 0);
    end
  endtask

  initial begin
    #(CYCLE * 200000);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(done_o == 1'b0 && status_o == 1'b0, "R1 reset flags", int'({done_o, status_o}), 0);
    chk(rd_data_o == 16'd0, "R1 reset data", int'(rd_data_o), 0);
    rst_ni = 1'b1;
    idle(2);

    // R4 underflow on empty store, all three consuming ops
    run(2'b01, 16'd0, "R4 pop empty");
    run(2'b10, 16'd0, "R4 add empty");
    run(2'b11, 16'd0, "R4 mul empty");
    idle(1);

    // R10 expression (25+17)*(3+2), with R7/R8/R9 along the way
    run(2'b00, 16'd25, "R10 push 25 R9");
    run(2'b00, 16'd17, "R10 push 17");
    run(2'b10, 16'd0,  "R10 add R7");
    run(2'b00, 16'd3,  "R10 push 3");
    run(2'b00, 16'd2,  "R10 push 2");
    run(2'b10, 16'd0,  "R10 add");
    run(2'b11, 16'd0,  "R10 mul R8");
    run(2'b01, 16'd0,  "R10 pop 210");
    chk(model_q.size() == 0, "R10 model empty", model_q.size(), 0);

    // R5 single operand: ops fail, entry survives
    run(2'b00, 16'd77, "R5 push");
    run(2'b10, 16'd0,  "R5 add one entry");
    run(2'b11, 16'd0,  "R5 mul one entry");
    run(2'b01, 16'd0,  "R5 pop survivor");

    // R3 fill, overflow, then drain in LIFO order (R6)
    for (int i = 1; i <= DEPTH; i++) run(2'b00, 16'(i * 100), "R3 fill");
    run(2'b00, 16'hBEEF, "R3 push full");
    for (int i = 0; i < DEPTH; i++) run(2'b01, 16'd0, "R6 drain");
    run(2'b01, 16'd0, "R4 pop after drain");
    idle(3);

    // R7 and R8 truncation
    run(2'b00, 16'hFFFF, "R7 push");
    run(2'b00, 16'd2,    "R7 push");
    run(2'b10, 16'd0,    "R7 add wraps");
    run(2'b01, 16'd0,    "R7 pop sum");
    run(2'b00, 16'd300,  "R8 push");
    run(2'b00, 16'd300,  "R8 push");
    run(2'b11, 16'd0,    "R8 mul truncates");
    run(2'b00, 16'd9,    "R6 push over result");
    run(2'b01, 16'd0,    "R6 pop 9");
    run(2'b01, 16'd0,    "R8 pop product");
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule